// File: doc/BRIEF.md
# Software-Accessible Return Address Stack

This block holds the return addresses of a small processor core. A call strobe moves the stack pointer up one slot and stores the program counter there. A return strobe hands back the address at the top of the stack and moves the pointer down one slot. Software can also reach the stack directly. It can read and load the pointer through a register port. It can read and rewrite the top entry through three byte-wide lanes, so return addresses can be redirected or planted for later returns.

The pointer is 5 bits wide. Slot 0 is not storage: it always reads as address zero, which leaves 31 real 21-bit entries. The upper lane carries entry bits 20:16 in its low five bits. The middle lane carries bits 15:8 and the low lane carries bits 7:0. Two sticky flags record a call that finds the stack full and a return that finds it empty. A configuration input selects whether an overflowing call also wraps the pointer back to slot 0.

Top module: `ret_addr_stack`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0, both flags are 0, and all three lanes and `ret_addr` read 0.
- R2: A call strobe accepted with pointer below 31 makes the pointer one higher on the next cycle. From that cycle on, the new top entry (on `ret_addr` and the lanes) equals the `call_pc` sampled with the strobe.
- R3: A return strobe with pointer above 0 shows the current top entry on `ret_addr` in the strobe cycle and makes the pointer one lower on the next cycle. The vacated entry keeps its contents and reads back when the pointer is loaded there again.
- R4: While the pointer is 0, `ret_addr` and all lanes read 0, and lane writes have no effect.
- R5: A pointer load with `ptr_wr` sets the pointer to `ptr_wdata`. The entry it selects (0 for slot 0) appears on `ret_addr` and the lanes on the following cycle.
- R6: Each lane write (`tos_up_wr` for bits 20:16, `tos_hi_wr` for bits 15:8, `tos_lo_wr` for bits 7:0, data on `tos_wdata`) changes only its own bits of the current top entry. A later return yields the modified address.
- R7: Bits 7:5 of `tos_up_rd` always read 0. The matching bits of `tos_wdata` are discarded on an upper-lane write.
- R8: A call strobe with pointer 31 and `cfg_ovf_clear` low sets `ovf_flag`. The pointer and every stored entry stay unchanged. `ovf_flag` stays set until reset.
- R9: A call strobe with pointer 31 and `cfg_ovf_clear` high sets `ovf_flag` and returns the pointer to 0.
- R10: A return strobe with pointer 0 shows 0 on `ret_addr`, leaves the pointer at 0 and sets `unf_flag`. `unf_flag` stays set until reset.
- R11: Only one operation takes effect per cycle, chosen in this priority order: call, then return, then pointer load, then lane writes. Every lower-ranked request in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ovf_clear | input | 1 | Overflowing call wraps the pointer to 0 |
| call_strobe | input | 1 | Push request |
| call_pc | input | 21 | Program counter to store on a push |
| ret_strobe | input | 1 | Pop request |
| ret_addr | output | 21 | Current top entry (the address returned by a pop) |
| ptr_wr | input | 1 | Pointer load strobe |
| ptr_wdata | input | 5 | New pointer value |
| ptr_rdata | output | 5 | Current pointer |
| tos_up_wr | input | 1 | Write upper lane (bits 20:16) |
| tos_hi_wr | input | 1 | Write middle lane (bits 15:8) |
| tos_lo_wr | input | 1 | Write low lane (bits 7:0) |
| tos_wdata | input | 8 | Lane write data |
| tos_up_rd | output | 8 | Upper lane, bits 7:5 zero |
| tos_hi_rd | output | 8 | Middle lane |
| tos_lo_rd | output | 8 | Low lane |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The properties assume that every input is a clean level that is stable at the clock edge and that reset is held for at least one edge before checking starts. They also assume `cfg_ovf_clear` stays constant for as long as an overflow check depends on it. The stimulus respects this. Inputs change only one time unit after a rising edge, and strobes drop back to idle after each cycle. `cfg_ovf_clear` changes only while reset is asserted. Pushes, pointer loads and pops cover every slot from 0 to 31, so every pointer value the checks reason about is reached.

// File: rtl/ras_pkg.sv
// Shared types for the return address stack.
// Assumes: nothing beyond the 1800-2017 language.
package ras_pkg;
    // Pointer operation chosen for a cycle, in falling priority.
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_LOAD = 2'd3
    } ptr_op_e;
endpackage

// File: rtl/ras_ptr_ctrl.sv
// Pointer and status control. Resolves the cycle's operation by priority
// (push, pop, load, idle), updates the pointer and the sticky flags, and
// reports whether a push will store data and whether lane writes may apply.
// Assumes: request inputs are synchronous to clk.
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             ovf_clear,
    output logic [PTR_W-1:0] ptr,
    output logic             ovf,
    output logic             unf,
    output logic             push_ok,
    output logic             lane_ok
);
    localparam logic [PTR_W-1:0] TOP = '1;
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    ptr_op_e op;

    // Pick the single operation that wins this cycle.
    always_comb begin
        if (push)      op = OP_PUSH;
        else if (pop)  op = OP_POP;
        else if (load) op = OP_LOAD;
        else           op = OP_NONE;
    end

    assign push_ok = (op == OP_PUSH) && (ptr != TOP);
    assign lane_ok = (op == OP_NONE);

    // Advance the pointer and latch the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            case (op)
                OP_PUSH: begin
                    if (ptr == TOP) begin
                        ovf <= 1'b1;
                        if (ovf_clear) ptr <= '0;
                    end else begin
                        ptr <= ptr + ONE;
                    end
                end
                OP_POP: begin
                    if (ptr == '0) unf <= 1'b1;
                    else           ptr <= ptr - ONE;
                end
                OP_LOAD: ptr <= load_val;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ras_store.sv
// Entry storage: 2**PTR_W - 1 registers of DATA_W bits for slots 1 and up.
// Slot 0 has no register and reads as zero. One write port, one read port.
// Assumes: a write never targets slot 0 (such a write is dropped).
module ras_store #(
    parameter int PTR_W  = 5,
    parameter int DATA_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int SLOTS = 1 << PTR_W;

    logic [DATA_W-1:0] slot [1:SLOTS-1];

    for (genvar g = 1; g < SLOTS; g++) begin : g_slot
        // Hold one entry; load it when the write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                              slot[g] <= '0;
            else if (we && widx == PTR_W'(g))        slot[g] <= wdata;
        end
    end

    // Select the addressed entry, zero for slot 0.
    always_comb begin
        rdata = '0;
        for (int i = 1; i < SLOTS; i++) begin
            if (ridx == PTR_W'(i)) rdata = slot[i];
        end
    end
endmodule

// File: rtl/ras_lane_map.sv
// Byte-lane view of an entry: splits it into upper/high/low read lanes and
// merges per-lane write data into a replacement entry.
// Assumes: 17 <= DATA_W <= 24, so the upper lane holds DATA_W-16 bits.
module ras_lane_map #(
    parameter int DATA_W = 21
) (
    input  logic [DATA_W-1:0] entry,
    input  logic [7:0]        wbyte,
    input  logic              up_we,
    input  logic              hi_we,
    input  logic              lo_we,
    output logic [7:0]        up_rd,
    output logic [7:0]        hi_rd,
    output logic [7:0]        lo_rd,
    output logic [DATA_W-1:0] merged
);
    localparam int UP_W = DATA_W - 16;

    assign up_rd = 8'(entry[DATA_W-1:16]);
    assign hi_rd = entry[15:8];
    assign lo_rd = entry[7:0];

    // Replace only the lanes whose write enable is set.
    always_comb begin
        merged = entry;
        if (lo_we) merged[7:0]         = wbyte;
        if (hi_we) merged[15:8]        = wbyte;
        if (up_we) merged[DATA_W-1:16] = wbyte[UP_W-1:0];
    end
endmodule

// File: rtl/ret_addr_stack.sv
// Return address stack with software access to pointer and top entry.
// Pushes store call_pc one slot above the pointer; pops step down; the
// top entry is visible combinationally on ret_addr and the byte lanes.
// Assumes: synchronous inputs; slot 0 is a fixed zero address.
module ret_addr_stack #(
    parameter int PTR_W  = 5,
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ovf_clear,
    input  logic              call_strobe,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic              ret_strobe,
    output logic [ADDR_W-1:0] ret_addr,
    input  logic              ptr_wr,
    input  logic [PTR_W-1:0]  ptr_wdata,
    output logic [PTR_W-1:0]  ptr_rdata,
    input  logic              tos_up_wr,
    input  logic              tos_hi_wr,
    input  logic              tos_lo_wr,
    input  logic [7:0]        tos_wdata,
    output logic [7:0]        tos_up_rd,
    output logic [7:0]        tos_hi_rd,
    output logic [7:0]        tos_lo_rd,
    output logic              ovf_flag,
    output logic              unf_flag
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0]  ptr;
    logic              push_ok;
    logic              lane_ok;
    logic [ADDR_W-1:0] tos;
    logic [ADDR_W-1:0] merged;
    logic              lane_we;
    logic              st_we;
    logic [PTR_W-1:0]  st_widx;
    logic [ADDR_W-1:0] st_wdata;

    ras_ptr_ctrl #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (call_strobe),
        .pop       (ret_strobe),
        .load      (ptr_wr),
        .load_val  (ptr_wdata),
        .ovf_clear (cfg_ovf_clear),
        .ptr       (ptr),
        .ovf       (ovf_flag),
        .unf       (unf_flag),
        .push_ok   (push_ok),
        .lane_ok   (lane_ok)
    );

    ras_lane_map #(.DATA_W(ADDR_W)) u_lanes (
        .entry  (tos),
        .wbyte  (tos_wdata),
        .up_we  (tos_up_wr),
        .hi_we  (tos_hi_wr),
        .lo_we  (tos_lo_wr),
        .up_rd  (tos_up_rd),
        .hi_rd  (tos_hi_rd),
        .lo_rd  (tos_lo_rd),
        .merged (merged)
    );

    // Route either a push or a lane update onto the single write port.
    always_comb begin
        lane_we  = lane_ok && (ptr != '0) && (tos_up_wr || tos_hi_wr || tos_lo_wr);
        st_we    = push_ok || lane_we;
        st_widx  = push_ok ? ptr + ONE : ptr;
        st_wdata = push_ok ? call_pc : merged;
    end

    ras_store #(.PTR_W(PTR_W), .DATA_W(ADDR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .widx  (st_widx),
        .wdata (st_wdata),
        .ridx  (ptr),
        .rdata (tos)
    );

    assign ret_addr  = tos;
    assign ptr_rdata = ptr;
endmodule

// File: rtl/ras_checker.sv
// Temporal checks on the return address stack ports; bound to the top.
// Assumes: inputs stable at clock edges, cfg_ovf_clear static.
module ras_checker #(
    parameter int PTR_W  = 5,
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_ovf_clear,
    input logic              call_strobe,
    input logic [ADDR_W-1:0] call_pc,
    input logic              ret_strobe,
    input logic [ADDR_W-1:0] ret_addr,
    input logic              ptr_wr,
    input logic [PTR_W-1:0]  ptr_rdata,
    input logic [7:0]        tos_up_rd,
    input logic [7:0]        tos_hi_rd,
    input logic [7:0]        tos_lo_rd,
    input logic              ovf_flag,
    input logic              unf_flag
);
    localparam logic [PTR_W-1:0] TOP = '1;
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
    localparam int               UP_W = ADDR_W - 16;

    // R2
    push_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_strobe && ptr_rdata != TOP |=>
        ptr_rdata == $past(ptr_rdata) + ONE && ret_addr == $past(call_pc));

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !call_strobe && ret_strobe && ptr_rdata != '0 |=>
        ptr_rdata == $past(ptr_rdata) - ONE);

    // R4
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rdata == '0 |->
        ret_addr == '0 && tos_up_rd == 8'h00 && tos_hi_rd == 8'h00 && tos_lo_rd == 8'h00);

    // R7
    upper_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tos_up_rd >> UP_W) == 8'h00);

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_strobe && ptr_rdata == TOP && !cfg_ovf_clear |=>
        ovf_flag && ptr_rdata == TOP && $stable(ret_addr));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R9
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_strobe && ptr_rdata == TOP && cfg_ovf_clear |=>
        ovf_flag && ptr_rdata == '0);

    // R10
    unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !call_strobe && ret_strobe && ptr_rdata == '0 |=>
        unf_flag && ptr_rdata == '0);

    // R10
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

    // R11
    push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_strobe && (ret_strobe || ptr_wr) && ptr_rdata != TOP |=>
        ptr_rdata == $past(ptr_rdata) + ONE);
endmodule

bind ret_addr_stack ras_checker #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ras_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ovf_clear (cfg_ovf_clear),
    .call_strobe   (call_strobe),
    .call_pc       (call_pc),
    .ret_strobe    (ret_strobe),
    .ret_addr      (ret_addr),
    .ptr_wr        (ptr_wr),
    .ptr_rdata     (ptr_rdata),
    .tos_up_rd     (tos_up_rd),
    .tos_hi_rd     (tos_hi_rd),
    .tos_lo_rd     (tos_lo_rd),
    .ovf_flag      (ovf_flag),
    .unf_flag      (unf_flag)
);

// File: tb/test_ret_addr_stack.sv
// Self-checking bench: sweeps pushes over every slot, loads every pointer
// value, pops back down, then probes lanes, priority and the flag corners.
module test_ret_addr_stack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ovf_clear = 1'b0;
    logic        call_strobe = 1'b0;
    logic [20:0] call_pc = '0;
    logic        ret_strobe = 1'b0;
    logic [20:0] ret_addr;
    logic        ptr_wr = 1'b0;
    logic [4:0]  ptr_wdata = '0;
    logic [4:0]  ptr_rdata;
    logic        tos_up_wr = 1'b0;
    logic        tos_hi_wr = 1'b0;
    logic        tos_lo_wr = 1'b0;
    logic [7:0]  tos_wdata = '0;
    logic [7:0]  tos_up_rd;
    logic [7:0]  tos_hi_rd;
    logic [7:0]  tos_lo_rd;
    logic        ovf_flag;
    logic        unf_flag;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ret_addr_stack i_ret_addr_stack (.*);

    function automatic logic [20:0] pc_of(int i);
        return 21'((i * 69857 + 3) & 32'h1FFFFF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all read views of the top entry against one value.
    task automatic chk_tos(string req, logic [20:0] exp);
        chk(req, 32'(ret_addr), 32'(exp));
        chk(req, 32'({tos_up_rd[4:0], tos_hi_rd, tos_lo_rd}), 32'(exp));
        chk(req, 32'(tos_up_rd[7:5]), 32'h0);
    endtask

    // One clock; inputs return to idle just after the edge.
    task automatic step();
        @(posedge clk);
        #1;
        call_strobe = 1'b0; ret_strobe = 1'b0; ptr_wr = 1'b0;
        tos_up_wr = 1'b0; tos_hi_wr = 1'b0; tos_lo_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic load_ptr(logic [4:0] p);
        ptr_wr = 1'b1; ptr_wdata = p;
        step();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 ptr", 32'(ptr_rdata), 0);
        chk("R1 ovf", 32'(ovf_flag), 0);
        chk("R1 unf", 32'(unf_flag), 0);
        chk_tos("R1 tos", 21'h0);

        // R10 pop on empty stack
        ret_strobe = 1'b1;
        #1 chk("R10 ret_addr at slot 0", 32'(ret_addr), 0);
        step();
        chk("R10 unf set", 32'(unf_flag), 1);
        chk("R10 ptr stays 0", 32'(ptr_rdata), 0);
        step();
        chk("R10 unf sticky", 32'(unf_flag), 1);

        do_reset();
        chk("R1 unf cleared", 32'(unf_flag), 0);
        // R4 lane writes at slot 0 ignored
        tos_wdata = 8'hAA; tos_up_wr = 1'b1; tos_hi_wr = 1'b1; tos_lo_wr = 1'b1;
        step();
        chk_tos("R4 slot 0 stays zero", 21'h0);

        // R2 fill every slot
        for (int i = 1; i <= 31; i++) begin
            call_strobe = 1'b1; call_pc = pc_of(i);
            step();
            chk("R2 ptr", 32'(ptr_rdata), 32'(i));
            chk_tos("R2 tos", pc_of(i));
        end
        chk("R8 ovf clear before full push", 32'(ovf_flag), 0);

        // R8 overflow without wrap
        call_strobe = 1'b1; call_pc = 21'h1FFFFF;
        step();
        chk("R8 ovf set", 32'(ovf_flag), 1);
        chk("R8 ptr held", 32'(ptr_rdata), 31);
        chk_tos("R8 data kept", pc_of(31));

        // R5 load every pointer value
        for (int p = 0; p < 32; p++) begin
            load_ptr(5'(p));
            chk("R5 ptr", 32'(ptr_rdata), 32'(p));
            chk_tos("R5 tos", (p == 0) ? 21'h0 : pc_of(p));
        end

        // R3 pop all the way down
        load_ptr(5'd31);
        for (int i = 31; i >= 1; i--) begin
            ret_strobe = 1'b1;
            #1 chk("R3 ret_addr in pop cycle", 32'(ret_addr), 32'(pc_of(i)));
            step();
            chk("R3 ptr", 32'(ptr_rdata), 32'(i - 1));
        end
        load_ptr(5'd5);
        chk_tos("R3 vacated entry kept", pc_of(5));
        chk("R8 ovf still set", 32'(ovf_flag), 1);

        // R6 and R7 lane writes at slot 5
        tos_wdata = 8'hFF; tos_up_wr = 1'b1;
        step();
        chk("R7 upper pad", 32'(tos_up_rd), 32'h1F);
        chk_tos("R6 upper lane", {5'h1F, pc_of(5)[15:0]});
        tos_wdata = 8'h3C; tos_hi_wr = 1'b1;
        step();
        chk_tos("R6 high lane", {5'h1F, 8'h3C, pc_of(5)[7:0]});
        tos_wdata = 8'hC3; tos_lo_wr = 1'b1;
        step();
        chk_tos("R6 low lane", 21'h1F3CC3);
        ret_strobe = 1'b1;
        #1 chk("R6 pop returns rewritten address", 32'(ret_addr), 32'h1F3CC3);
        step();
        chk("R6 ptr after pop", 32'(ptr_rdata), 4);

        // R11 push beats pop, load and lane write
        call_strobe = 1'b1; call_pc = 21'h0ABCDE; ret_strobe = 1'b1;
        ptr_wr = 1'b1; ptr_wdata = 5'd20; tos_lo_wr = 1'b1; tos_wdata = 8'h11;
        step();
        chk("R11 push wins ptr", 32'(ptr_rdata), 5);
        chk_tos("R11 push wins data", 21'h0ABCDE);
        // R11 pop beats load
        ret_strobe = 1'b1; ptr_wr = 1'b1; ptr_wdata = 5'd9;
        step();
        chk("R11 pop wins ptr", 32'(ptr_rdata), 4);
        // R11 load beats lane write
        ptr_wr = 1'b1; ptr_wdata = 5'd9; tos_lo_wr = 1'b1; tos_wdata = 8'h55;
        step();
        chk("R11 load ptr", 32'(ptr_rdata), 9);
        chk_tos("R11 new slot untouched", pc_of(9));
        load_ptr(5'd4);
        chk_tos("R11 old slot untouched", pc_of(4));

        // R9 overflow with wrap
        rst_n = 1'b0; cfg_ovf_clear = 1'b1;
        step(); step();
        rst_n = 1'b1;
        chk("R1 ovf cleared", 32'(ovf_flag), 0);
        load_ptr(5'd31);
        call_strobe = 1'b1; call_pc = 21'h012345;
        step();
        chk("R9 ptr wraps", 32'(ptr_rdata), 0);
        chk("R9 ovf set", 32'(ovf_flag), 1);
        call_strobe = 1'b1; call_pc = 21'h054321;
        step();
        chk("R9 push after wrap", 32'(ptr_rdata), 1);
        chk_tos("R9 push data", 21'h054321);
        chk("R8 ovf sticky", 32'(ovf_flag), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule